// File: doc/BRIEF.md
# Trap arbitration and vectoring unit

This block sits beside a 16-bit processor core and decides which exception the core services next. It takes condition pulses from three reset sources, three urgent hardware traps (class A: non-maskable interrupt, stack overflow, stack underflow), five program-fault traps (class B), and a software trap instruction carrying a 7-bit trap number. Every accepted condition is remembered as pending. The highest-ranked pending request is presented to the core as a 24-bit vector address, a trap number and a service tier. The core accepts it with a valid/acknowledge handshake.

The block also keeps a sticky flag register with one bit per class A and class B cause. All class B faults share one vector, so a handler tells them apart by reading these flags. Software clears a flag by writing 0 to its bit. A software trap is serviced at the processor's current interrupt level rather than at a trap tier, so the core receives that level with the request. Any reset source discards everything pending and every flag, and steers the core to address 0.

Top module: `trap_arbiter`

## Requirements
- R1: Any bit of `rst_src_i` (bit 0 hardware reset, bit 1 reset instruction, bit 2 watchdog overflow) leads to a presented request with vector 0x000000, number 0x00 and tier code 3. This request replaces any request currently presented.
- R2: Class A requests `a_trap_i[0]` (non-maskable interrupt), `[1]` (stack overflow) and `[2]` (stack underflow) are presented with numbers 0x02, 0x04 and 0x06, vectors 0x000008, 0x000010 and 0x000018, and tier code 2.
- R3: Any bit of `b_fault_i` leads to a single request with vector 0x000028, number 0x0A and tier code 1. Several class B faults pending together produce one dispatch.
- R4: The flag register `flags_o` holds class B fault `b_fault_i[i]` in bit i (bits 4..0) and class A trap `a_trap_i[j]` in bit 5+j (bits 7..5). A bit is set in the cycle after its condition is seen.
- R5: A software trap (`sw_trap_i` with number N) is presented with number N, vector N×4 (0x000000 to 0x0001FC), tier code 0, and `vec_level_o` equal to `cpu_ilvl_i` captured in the request cycle. Hardware requests present level 0.
- R6: While a hardware request (tier code 1, 2 or 3) is presented, its number is never in the reserved range 0x0B to 0x0F.
- R7: Ranking is reset, then class A (lower index first), then class B, then software trap. Lower-ranked requests stay pending and are presented after the higher one is acknowledged.
- R8: Flags are sticky. A write (`flag_wr_i`) clears each bit where `flag_wdata_i` is 0, and a 1 in the write data leaves that bit unchanged.
- R9: A condition that arrives in the same cycle as a write clearing its flag leaves the flag set.
- R10: A presented request stays unchanged while `vec_valid_o` is high and `vec_ack_i` is low, unless a request of strictly higher tier replaces it. A request of the same or a lower tier does not replace it. After an acknowledge, `vec_valid_o` is low for the next cycle.
- R11: A reset source clears all flags and all pending class A, class B and software requests. A class A or B condition arriving in the same cycle does not set its flag.
- R12: After `rst`, `vec_valid_o` is 0, `flags_o` is 0, and the vector outputs show address 0, number 0, tier code 3, level 0.
- R13: A condition sampled at clock edge k is presented after edge k+1. A request pending behind an acknowledged one is presented one cycle after the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_src_i | input | 3 | Reset source conditions |
| a_trap_i | input | 3 | Class A trap conditions |
| b_fault_i | input | 5 | Class B fault conditions |
| sw_trap_i | input | 1 | Software trap instruction request |
| sw_num_i | input | 7 | Software trap number |
| cpu_ilvl_i | input | 4 | Current CPU interrupt level |
| flag_wr_i | input | 1 | Flag register write strobe |
| flag_wdata_i | input | 8 | Flag write data (0 clears a bit) |
| flags_o | output | 8 | Sticky trap flag register |
| vec_valid_o | output | 1 | Request presented to the core |
| vec_ack_i | input | 1 | Core accepts the presented request |
| vec_addr_o | output | 24 | Vector address |
| vec_num_o | output | 7 | Trap number |
| vec_tier_o | output | 2 | Tier: 3 reset, 2 class A, 1 class B, 0 software |
| vec_level_o | output | 4 | Service level for a software trap, else 0 |

## Verification
The bench targets several corner cases. One is simultaneous arrival of class A, class B and a software trap: an arbiter that dropped losers instead of keeping them pending would never show the later vectors. Another is a class A trap arriving while one of the same tier is presented, and a higher tier arriving while a software trap waits: a design comparing tiers wrongly would either swap in the same-tier request or strand the software trap behind it. A third is a flag clear coinciding with a new set, where a design giving the write priority would lose a fault cause. The last is a reset source coinciding with a new trap: a design letting the trap survive would leave a stale flag and a stray dispatch after the reset vector.

// File: rtl/trap_pkg.sv
package trap_pkg;

  // Service tier code presented to the core
  typedef enum logic [1:0] {
    TIER_SW   = 2'd0,
    TIER_I    = 2'd1,
    TIER_II   = 2'd2,
    TIER_III  = 2'd3
  } tier_e;

  // Which pending source a presented request came from
  typedef enum logic [1:0] {
    KIND_RST = 2'd0,
    KIND_A   = 2'd1,
    KIND_B   = 2'd2,
    KIND_SW  = 2'd3
  } kind_e;

  // Trap number plan: vector = number * 4
  localparam int RST_NUM    = 0;
  localparam int A_NUM_BASE = 2;
  localparam int A_NUM_STEP = 2;
  localparam int B_NUM      = 10;
  localparam int RSV_LO     = 11;
  localparam int RSV_HI     = 15;

endpackage

// File: rtl/trap_flags.sv
module trap_flags
  import trap_pkg::*;
#(
  parameter int N_A = 3,
  parameter int N_B = 5,
  localparam int FW = N_A + N_B
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          any_rst,
  input  logic [N_A-1:0] a_set,
  input  logic [N_B-1:0] b_set,
  input  logic          wr,
  input  logic [FW-1:0] wdata,
  output logic [FW-1:0] flags
);

  logic [FW-1:0] set_vec;
  logic [FW-1:0] kept;
  logic [FW-1:0] flags_q;

  assign set_vec = {a_set, b_set};
  // software may only clear: a 1 in the write data keeps the bit
  assign kept    = wr ? (flags_q & wdata) : flags_q;

  always_ff @(posedge clk) begin
    if (rst || any_rst) flags_q <= '0;
    else                flags_q <= kept | set_vec;
  end

  assign flags = flags_q;

  // bits only fall through a software write or a reset source
  assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (!wr && !any_rst) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  // a reset source wipes every flag, even with a condition present
  assert_rstclr_R11: assert property (@(posedge clk) disable iff (rst)
    any_rst |=> (flags_q == '0));

  // a newly seen condition survives a coincident clear
  assert_setwins_R9: assert property (@(posedge clk) disable iff (rst)
    (!any_rst && (set_vec != '0)) |=> ((flags_q & $past(set_vec)) == $past(set_vec)));

endmodule

// File: rtl/trap_pending.sv
module trap_pending
  import trap_pkg::*;
#(
  parameter int N_A   = 3,
  parameter int NUM_W = 7,
  parameter int LVL_W = 4,
  localparam int AI_W = (N_A > 1) ? $clog2(N_A) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             any_rst,
  input  logic [N_A-1:0]   a_set,
  input  logic             b_any,
  input  logic             sw_req,
  input  logic [NUM_W-1:0] sw_num,
  input  logic [LVL_W-1:0] sw_lvl,
  input  logic             fire,
  input  kind_e            fire_kind,
  input  logic [AI_W-1:0]  fire_aidx,
  output logic             pend_rst,
  output logic [N_A-1:0]   pend_a,
  output logic             pend_b,
  output logic             pend_sw,
  output logic [NUM_W-1:0] sw_num_q,
  output logic [LVL_W-1:0] sw_lvl_q
);

  logic             rst_q;
  logic [N_A-1:0]   a_q;
  logic             b_q;
  logic             sw_q;
  logic [NUM_W-1:0] num_q;
  logic [LVL_W-1:0] lvl_q;
  logic [N_A-1:0]   a_clr;

  // one-hot clear of the class A entry just accepted by the core
  for (genvar g = 0; g < N_A; g++) begin : g_aclr
    assign a_clr[g] = fire && (fire_kind == KIND_A) && (fire_aidx == AI_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_q <= 1'b0;
      a_q   <= '0;
      b_q   <= 1'b0;
      sw_q  <= 1'b0;
      num_q <= '0;
      lvl_q <= '0;
    end else if (any_rst) begin
      rst_q <= 1'b1;
      a_q   <= '0;
      b_q   <= 1'b0;
      sw_q  <= 1'b0;
    end else begin
      // a fresh condition wins over the clear of the accepted request
      rst_q <= rst_q && !(fire && fire_kind == KIND_RST);
      a_q   <= (a_q & ~a_clr) | a_set;
      b_q   <= (b_q && !(fire && fire_kind == KIND_B)) || b_any;
      if (sw_req) begin
        sw_q  <= 1'b1;
        num_q <= sw_num;
        lvl_q <= sw_lvl;
      end else if (fire && fire_kind == KIND_SW) begin
        sw_q  <= 1'b0;
      end
    end
  end

  assign pend_rst = rst_q;
  assign pend_a   = a_q;
  assign pend_b   = b_q;
  assign pend_sw  = sw_q;
  assign sw_num_q = num_q;
  assign sw_lvl_q = lvl_q;

  // a reset source leaves only the reset request pending
  assert_rstpend_R11: assert property (@(posedge clk) disable iff (rst)
    any_rst |=> (rst_q && (a_q == '0) && !b_q && !sw_q));

  // pending class A entries are never lost without an acknowledge or reset
  assert_akeep_R7: assert property (@(posedge clk) disable iff (rst)
    (!any_rst && !fire) |=> ((a_q & $past(a_q)) == $past(a_q)));

endmodule

// File: rtl/trap_select.sv
module trap_select
  import trap_pkg::*;
#(
  parameter int N_A   = 3,
  parameter int NUM_W = 7,
  parameter int LVL_W = 4,
  localparam int AI_W = (N_A > 1) ? $clog2(N_A) : 1
) (
  input  logic             pend_rst,
  input  logic [N_A-1:0]   pend_a,
  input  logic             pend_b,
  input  logic             pend_sw,
  input  logic [NUM_W-1:0] sw_num_q,
  input  logic [LVL_W-1:0] sw_lvl_q,
  output logic             cand_valid,
  output kind_e            cand_kind,
  output logic [AI_W-1:0]  cand_aidx,
  output tier_e            cand_tier,
  output logic [NUM_W-1:0] cand_num,
  output logic [LVL_W-1:0] cand_lvl
);

  logic [NUM_W-1:0] a_num_tab [N_A];
  logic             a_hit;
  logic [AI_W-1:0]  a_idx;

  // class A trap numbers laid out at a fixed stride
  for (genvar g = 0; g < N_A; g++) begin : g_anum
    assign a_num_tab[g] = NUM_W'(A_NUM_BASE + A_NUM_STEP * g);
  end

  // lowest index (lowest vector) wins inside class A
  always_comb begin
    a_hit = 1'b0;
    a_idx = '0;
    for (int i = N_A - 1; i >= 0; i--) begin
      if (pend_a[i]) begin
        a_hit = 1'b1;
        a_idx = AI_W'(i);
      end
    end
  end

  always_comb begin
    cand_valid = 1'b1;
    cand_kind  = KIND_RST;
    cand_aidx  = '0;
    cand_tier  = TIER_III;
    cand_num   = NUM_W'(RST_NUM);
    cand_lvl   = '0;
    if (pend_rst) begin
      cand_kind  = KIND_RST;
    end else if (a_hit) begin
      cand_kind  = KIND_A;
      cand_aidx  = a_idx;
      cand_tier  = TIER_II;
      cand_num   = a_num_tab[a_idx];
    end else if (pend_b) begin
      cand_kind  = KIND_B;
      cand_tier  = TIER_I;
      cand_num   = NUM_W'(B_NUM);
    end else if (pend_sw) begin
      cand_kind  = KIND_SW;
      cand_tier  = TIER_SW;
      cand_num   = sw_num_q;
      cand_lvl   = sw_lvl_q;
    end else begin
      cand_valid = 1'b0;
    end
  end

endmodule

// File: rtl/trap_present.sv
module trap_present
  import trap_pkg::*;
#(
  parameter int N_A    = 3,
  parameter int NUM_W  = 7,
  parameter int LVL_W  = 4,
  parameter int ADDR_W = 24,
  localparam int AI_W  = (N_A > 1) ? $clog2(N_A) : 1,
  localparam int PAD_W = ADDR_W - NUM_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cand_valid,
  input  kind_e             cand_kind,
  input  logic [AI_W-1:0]   cand_aidx,
  input  tier_e             cand_tier,
  input  logic [NUM_W-1:0]  cand_num,
  input  logic [LVL_W-1:0]  cand_lvl,
  input  logic              ack,
  output logic              valid,
  output logic [ADDR_W-1:0] addr,
  output logic [NUM_W-1:0]  num,
  output tier_e             tier,
  output logic [LVL_W-1:0]  lvl,
  output logic              fire,
  output kind_e             fire_kind,
  output logic [AI_W-1:0]   fire_aidx
);

  logic              valid_q;
  logic [ADDR_W-1:0] addr_q;
  logic [NUM_W-1:0]  num_q;
  tier_e             tier_q;
  logic [LVL_W-1:0]  lvl_q;
  kind_e             kind_q;
  logic [AI_W-1:0]   aidx_q;
  logic              load;

  assign fire = valid_q && ack;
  // take a new request when idle, or pre-empt with a strictly higher tier
  assign load = !fire && cand_valid && (!valid_q || (cand_tier > tier_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      num_q   <= NUM_W'(RST_NUM);
      tier_q  <= TIER_III;
      lvl_q   <= '0;
      kind_q  <= KIND_RST;
      aidx_q  <= '0;
    end else if (fire) begin
      valid_q <= 1'b0;
    end else if (load) begin
      valid_q <= 1'b1;
      addr_q  <= {{PAD_W{1'b0}}, cand_num, 2'b00};
      num_q   <= cand_num;
      tier_q  <= cand_tier;
      lvl_q   <= cand_lvl;
      kind_q  <= cand_kind;
      aidx_q  <= cand_aidx;
    end
  end

  assign valid     = valid_q;
  assign addr      = addr_q;
  assign num       = num_q;
  assign tier      = tier_q;
  assign lvl       = lvl_q;
  assign fire_kind = kind_q;
  assign fire_aidx = aidx_q;

  // held until accepted, unless a higher tier took its place
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !ack) |=> (valid_q && ((tier_q > $past(tier_q)) ||
                                       ((num_q == $past(num_q)) && (tier_q == $past(tier_q))))));

  // one idle cycle follows every acknowledge
  assert_drop_R10: assert property (@(posedge clk) disable iff (rst)
    (valid_q && ack) |=> !valid_q);

  // hardware requests never carry a reserved number
  assert_rsv_R6: assert property (@(posedge clk) disable iff (rst)
    (valid_q && (tier_q != TIER_SW)) |->
      !((num_q >= NUM_W'(RSV_LO)) && (num_q <= NUM_W'(RSV_HI))));

  // the top tier always means the reset vector at level 0
  assert_rstvec_R1: assert property (@(posedge clk) disable iff (rst)
    (valid_q && (tier_q == TIER_III)) |-> ((num_q == '0) && (lvl_q == '0)));

endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
#(
  parameter int N_RST  = 3,
  parameter int N_A    = 3,
  parameter int N_B    = 5,
  parameter int NUM_W  = 7,
  parameter int LVL_W  = 4,
  parameter int ADDR_W = 24,
  localparam int FW    = N_A + N_B,
  localparam int AI_W  = (N_A > 1) ? $clog2(N_A) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_RST-1:0]  rst_src_i,
  input  logic [N_A-1:0]    a_trap_i,
  input  logic [N_B-1:0]    b_fault_i,
  input  logic              sw_trap_i,
  input  logic [NUM_W-1:0]  sw_num_i,
  input  logic [LVL_W-1:0]  cpu_ilvl_i,
  input  logic              flag_wr_i,
  input  logic [FW-1:0]     flag_wdata_i,
  output logic [FW-1:0]     flags_o,
  output logic              vec_valid_o,
  input  logic              vec_ack_i,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic [NUM_W-1:0]  vec_num_o,
  output logic [1:0]        vec_tier_o,
  output logic [LVL_W-1:0]  vec_level_o
);

  logic             any_rst;
  logic             b_any;
  logic             pend_rst, pend_b, pend_sw;
  logic [N_A-1:0]   pend_a;
  logic [NUM_W-1:0] sw_num_q;
  logic [LVL_W-1:0] sw_lvl_q;
  logic             cand_valid;
  kind_e            cand_kind;
  logic [AI_W-1:0]  cand_aidx;
  tier_e            cand_tier;
  logic [NUM_W-1:0] cand_num;
  logic [LVL_W-1:0] cand_lvl;
  logic             fire;
  kind_e            fire_kind;
  logic [AI_W-1:0]  fire_aidx;
  tier_e            tier;

  assign any_rst = |rst_src_i;
  assign b_any   = |b_fault_i;

  trap_flags #(.N_A(N_A), .N_B(N_B)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .any_rst (any_rst),
    .a_set   (a_trap_i),
    .b_set   (b_fault_i),
    .wr      (flag_wr_i),
    .wdata   (flag_wdata_i),
    .flags   (flags_o)
  );

  trap_pending #(.N_A(N_A), .NUM_W(NUM_W), .LVL_W(LVL_W)) u_pend (
    .clk       (clk),
    .rst       (rst),
    .any_rst   (any_rst),
    .a_set     (a_trap_i),
    .b_any     (b_any),
    .sw_req    (sw_trap_i),
    .sw_num    (sw_num_i),
    .sw_lvl    (cpu_ilvl_i),
    .fire      (fire),
    .fire_kind (fire_kind),
    .fire_aidx (fire_aidx),
    .pend_rst  (pend_rst),
    .pend_a    (pend_a),
    .pend_b    (pend_b),
    .pend_sw   (pend_sw),
    .sw_num_q  (sw_num_q),
    .sw_lvl_q  (sw_lvl_q)
  );

  trap_select #(.N_A(N_A), .NUM_W(NUM_W), .LVL_W(LVL_W)) u_sel (
    .pend_rst   (pend_rst),
    .pend_a     (pend_a),
    .pend_b     (pend_b),
    .pend_sw    (pend_sw),
    .sw_num_q   (sw_num_q),
    .sw_lvl_q   (sw_lvl_q),
    .cand_valid (cand_valid),
    .cand_kind  (cand_kind),
    .cand_aidx  (cand_aidx),
    .cand_tier  (cand_tier),
    .cand_num   (cand_num),
    .cand_lvl   (cand_lvl)
  );

  trap_present #(.N_A(N_A), .NUM_W(NUM_W), .LVL_W(LVL_W), .ADDR_W(ADDR_W)) u_pres (
    .clk        (clk),
    .rst        (rst),
    .cand_valid (cand_valid),
    .cand_kind  (cand_kind),
    .cand_aidx  (cand_aidx),
    .cand_tier  (cand_tier),
    .cand_num   (cand_num),
    .cand_lvl   (cand_lvl),
    .ack        (vec_ack_i),
    .valid      (vec_valid_o),
    .addr       (vec_addr_o),
    .num        (vec_num_o),
    .tier       (tier),
    .lvl        (vec_level_o),
    .fire       (fire),
    .fire_kind  (fire_kind),
    .fire_aidx  (fire_aidx)
  );

  assign vec_tier_o = tier;

endmodule

// File: tb/trap_arbiter_bench.sv
module trap_arbiter_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  rsrc;
  logic [2:0]  a_in;
  logic [4:0]  b_in;
  logic        sw;
  logic [6:0]  swnum;
  logic [3:0]  ilvl;
  logic        wr;
  logic [7:0]  wd;
  logic        ack;
  logic [7:0]  flags;
  logic        valid;
  logic [23:0] addr;
  logic [6:0]  num;
  logic [1:0]  tier;
  logic [3:0]  lvl;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #2 clk = ~clk;

  trap_arbiter u_trap_arbiter (
    .clk(clk), .rst(rst), .rst_src_i(rsrc), .a_trap_i(a_in), .b_fault_i(b_in),
    .sw_trap_i(sw), .sw_num_i(swnum), .cpu_ilvl_i(ilvl), .flag_wr_i(wr),
    .flag_wdata_i(wd), .flags_o(flags), .vec_valid_o(valid), .vec_ack_i(ack),
    .vec_addr_o(addr), .vec_num_o(num), .vec_tier_o(tier), .vec_level_o(lvl)
  );

  // ---------------- behavioural reference model ----------------
  int m_flags = 0;
  bit m_pr = 0, m_pb = 0, m_ps = 0;
  bit [2:0] m_pa = 0;
  int m_sn = 0, m_sl = 0;
  bit m_v = 0;
  int m_num = 0, m_tier = 3, m_lvl = 0, m_kind = 0, m_aidx = 0;

  always @(posedge clk) begin
    bit cv, fire, anyr;
    int ck, ct, cn, cl, ca, fk, fa;
    if (rst) begin
      m_flags = 0; m_pr = 0; m_pa = 0; m_pb = 0; m_ps = 0; m_sn = 0; m_sl = 0;
      m_v = 0; m_num = 0; m_tier = 3; m_lvl = 0; m_kind = 0; m_aidx = 0;
    end else begin
      fire = m_v && ack; fk = m_kind; fa = m_aidx;
      cv = 1; ck = 0; ct = 3; cn = 0; cl = 0; ca = 0;
      if (m_pr) begin
        ck = 0;
      end else if (m_pa != 0) begin
        ca = m_pa[0] ? 0 : (m_pa[1] ? 1 : 2);
        ck = 1; ct = 2; cn = 2 + 2 * ca;
      end else if (m_pb) begin
        ck = 2; ct = 1; cn = 10;
      end else if (m_ps) begin
        ck = 3; ct = 0; cn = m_sn; cl = m_sl;
      end else cv = 0;
      if (fire) m_v = 0;
      else if (cv && (!m_v || ct > m_tier)) begin
        m_v = 1; m_num = cn; m_tier = ct; m_lvl = cl; m_kind = ck; m_aidx = ca;
      end
      anyr = (rsrc != 0);
      if (anyr) begin
        m_pr = 1; m_pa = 0; m_pb = 0; m_ps = 0; m_flags = 0;
      end else begin
        if (fire && fk == 0) m_pr = 0;
        if (fire && fk == 1) m_pa[fa] = 0;
        m_pa = m_pa | a_in;
        if (fire && fk == 2) m_pb = 0;
        if (b_in != 0) m_pb = 1;
        if (sw) begin m_ps = 1; m_sn = swnum; m_sl = ilvl; end
        else if (fire && fk == 3) m_ps = 0;
        if (wr) m_flags = m_flags & wd;
        m_flags = m_flags | {a_in, b_in};
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // compare against the model on every clock, away from the edge
  always @(negedge clk) begin
    chk("R4 flags vs model", flags, m_flags);
    chk("R10 valid vs model", valid, m_v);
    chk("R7 number vs model", num, m_num);
    chk("R5 address vs model", addr, m_num * 4);
    chk("R7 tier vs model", tier, m_tier);
    chk("R5 level vs model", lvl, m_lvl);
    if (valid && tier != 0)
      chk("R6 reserved number", (num >= 11 && num <= 15) ? 1 : 0, 0);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic expect_vec(input bit v, input int ad, input int t, input int l, input string tag);
    chk({tag, " valid"}, valid, v);
    chk({tag, " address"}, addr, ad);
    chk({tag, " tier"}, tier, t);
    chk({tag, " level"}, lvl, l);
  endtask

  task automatic do_ack();
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    chk("R10 valid low after ack", valid, 0);
    @(negedge clk);
  endtask

  initial begin
    rst = 1; rsrc = 0; a_in = 0; b_in = 0; sw = 0; swnum = 0; ilvl = 0;
    wr = 0; wd = 0; ack = 0;
    repeat (3) @(negedge clk);
    expect_vec(0, 0, 3, 0, "R12 reset state");
    chk("R12 flags after reset", flags, 0);
    rst = 0; @(negedge clk);

    // class A, latency and flag position
    a_in = 3'b001; @(negedge clk); a_in = 0;
    chk("R13 not yet presented", valid, 0);
    chk("R4 nmi flag bit 5", flags, 8'h20);
    @(negedge clk); expect_vec(1, 8, 2, 0, "R2 nmi");
    chk("R2 nmi number", num, 2);
    do_ack();

    // simultaneous class A and class B
    a_in = 3'b110; b_in = 5'b10000; @(negedge clk); a_in = 0; b_in = 0;
    @(negedge clk); expect_vec(1, 16, 2, 0, "R7 stack overflow first");
    do_ack(); expect_vec(1, 24, 2, 0, "R7 stack underflow next");
    do_ack(); expect_vec(1, 40, 1, 0, "R3 class B last");
    chk("R3 class B number", num, 10);
    do_ack();
    chk("R7 nothing left pending", valid, 0);
    chk("R4 flags after burst", flags, 8'hF0);

    // flag writes
    wr = 1; wd = 8'h7F; @(negedge clk); wr = 0;
    chk("R8 write clears zero bits only", flags, 8'h70);
    wr = 1; wd = 8'h00; b_in = 5'b00001; @(negedge clk); wr = 0; b_in = 0;
    chk("R9 set beats clear", flags, 8'h01);
    @(negedge clk); expect_vec(1, 40, 1, 0, "R3 bus fault");
    do_ack();

    // software trap, pre-emption, same-tier hold
    sw = 1; swnum = 7'h7F; ilvl = 4'd5; @(negedge clk); sw = 0; ilvl = 4'd9;
    @(negedge clk); expect_vec(1, 'h1FC, 0, 5, "R5 software trap");
    a_in = 3'b010; @(negedge clk); a_in = 0;
    @(negedge clk); expect_vec(1, 16, 2, 0, "R10 higher tier replaces");
    a_in = 3'b001; @(negedge clk); a_in = 0;
    @(negedge clk); expect_vec(1, 16, 2, 0, "R10 same tier holds");
    do_ack(); expect_vec(1, 8, 2, 0, "R7 nmi after overflow");
    do_ack(); expect_vec(1, 'h1FC, 0, 5, "R5 software trap resumes");
    do_ack();

    // reset source override
    b_in = 5'b00100; @(negedge clk); b_in = 0;
    @(negedge clk); expect_vec(1, 40, 1, 0, "R3 operand fault");
    rsrc = 3'b100; a_in = 3'b001; sw = 1; swnum = 7'h21; @(negedge clk);
    rsrc = 0; a_in = 0; sw = 0;
    chk("R11 flags cleared by reset source", flags, 0);
    @(negedge clk); expect_vec(1, 0, 3, 0, "R1 watchdog reset vector");
    do_ack(); @(negedge clk);
    chk("R11 nothing pending after reset", valid, 0);
    rsrc = 3'b010; @(negedge clk); rsrc = 0;
    @(negedge clk); expect_vec(1, 0, 3, 0, "R1 reset instruction");
    do_ack();

    // random traffic checked against the model
    for (int i = 0; i < 4000; i++) begin
      rst   = ($urandom_range(0, 599) == 0);
      rsrc  = ($urandom_range(0, 199) == 0) ? 3'($urandom_range(1, 7)) : 3'b0;
      a_in  = ($urandom_range(0, 9) == 0) ? 3'($urandom) : 3'b0;
      b_in  = ($urandom_range(0, 9) == 0) ? 5'($urandom) : 5'b0;
      sw    = ($urandom_range(0, 11) == 0);
      swnum = 7'($urandom);
      ilvl  = 4'($urandom);
      wr    = ($urandom_range(0, 19) == 0);
      wd    = 8'($urandom);
      ack   = ($urandom_range(0, 2) == 0);
      @(negedge clk);
    end
    rst = 0; rsrc = 0; a_in = 0; b_in = 0; sw = 0; wr = 0; ack = 0;
    repeat (4) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule